// File: doc/BRIEF.md
# Mersenne-Prime Cache Line Mapper

This block maps line addresses onto the sets of a direct-mapped data cache whose number of usable lines is a Mersenne number 2^C − 1. Conventional caches take the low address bits as the set index. Under that mapping, strides that are powers of two make the elements of a vector pile onto one line. Here the index is the line address reduced modulo 2^C − 1, so those strides walk through distinct lines. The reduction splits the address into C-bit slices and adds them with an end-around carry, then folds an all-ones sum to zero. Its depth is a short chain of narrow adders, comparable to an ordinary address add.

A second path supports strided vector streams. It holds a running address and a running index. On each step it advances both: the address by the stride, and the index by the pre-reduced stride through a single C-bit end-around adder. The index is therefore ready in the same cycle as the next address, with no full reduction needed. A small tag-compare wrapper keeps one valid bit and a full-address tag per line. It answers a lookup one cycle after the request and allocates the line on a miss. A lookup takes its address either from the request port or from the stream path.

Top module: `mersenne_line_mapper`

## Requirements
- R1: `idx_out` equals `req_addr` modulo P = 2^C_W − 1, combinationally, in the same cycle.
- R2: The value 2^C_W − 1 never appears on `idx_out`, `rsp_index` or `seq_index`. Every address that is a multiple of P gives index 0.
- R3: `tag_out` equals the full `req_addr`, so two addresses that share an index always have different tags.
- R4: The addresses k·2^C_W for k = 0..P−1 map to index k, so a power-of-two stride of 2^C_W spreads over distinct lines.
- R5: A request with `req_valid` high at a clock edge gives `rsp_valid` high after exactly that edge, with `rsp_index` equal to the index of the looked-up address. Without a request, `rsp_valid` is low.
- R6: `rsp_hit` is 1 only when the line at that index is valid and its stored tag equals the looked-up address. On a miss the line becomes valid with the new tag, replacing the old one. A repeated lookup of the same address therefore hits, and a different address with the same index evicts it.
- R7: At a clock edge, `seq_load` sets `seq_addr` to `seq_base` and `seq_index` to `seq_base` mod P, and captures `seq_stride` for later steps.
- R8: At a clock edge, `seq_step` adds the captured stride to `seq_addr` (modulo 2^ADDR_W). It also sets `seq_index` to (`seq_index` + stride mod P) mod P, which equals `seq_addr` mod P as long as the address has not wrapped.
- R9: `seq_load` takes priority over `seq_step`. With neither asserted, `seq_addr` and `seq_index` hold their values.
- R10: With `req_sel_seq` = 1, a lookup uses `seq_addr` and `seq_index` in place of `req_addr` and its index.
- R11: After reset, all lines are invalid, `rsp_valid` is 0, and `seq_addr`, `seq_index` and the captured stride are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_sel_seq | input | 1 | Take the lookup address from the stream path |
| req_addr | input | ADDR_W | Line address for lookup and mapping |
| idx_out | output | C_W | Set index of `req_addr` |
| tag_out | output | ADDR_W | Tag of `req_addr` |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_index | output | C_W | Index that was looked up |
| seq_load | input | 1 | Load stream base and stride |
| seq_step | input | 1 | Advance stream by stride |
| seq_base | input | ADDR_W | Stream start address |
| seq_stride | input | ADDR_W | Stream stride |
| seq_addr | output | ADDR_W | Current stream address |
| seq_index | output | C_W | Current stream index |

## Verification
The bench builds the block with ADDR_W = 16 and C_W = 5, giving 31 usable lines. With four slices to fold, the carry path from the top slice back into the bottom one is exercised. At this size, addresses such as 31, 961 and 0x7C00 land on the same line as address 0, so evictions can be provoked with a handful of lookups. The table walks addresses that need more than one end-around wrap. Directed tests then step streams with strides of 64 and 31, which check the incremental index against a bench-side modulo.

// File: rtl/mersenne_line_mapper.sv
module mersenne_line_mapper #(
  parameter int ADDR_W = 16,
  parameter int C_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_sel_seq,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [C_W-1:0]    idx_out,
  output logic [ADDR_W-1:0] tag_out,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [C_W-1:0]    rsp_index,
  input  logic              seq_load,
  input  logic              seq_step,
  input  logic [ADDR_W-1:0] seq_base,
  input  logic [ADDR_W-1:0] seq_stride,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [C_W-1:0]    seq_index
);
  localparam int NCH   = (ADDR_W + C_W - 1) / C_W;
  localparam int PAD_W = NCH * C_W;
  localparam int LINES = 1 << C_W;
  localparam logic [C_W-1:0] TOP = '1;

  function automatic logic [C_W-1:0] eac_add(input logic [C_W-1:0] a, input logic [C_W-1:0] b);
    logic [C_W:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[C_W-1:0] + {{(C_W-1){1'b0}}, t[C_W]};
  endfunction

  function automatic logic [C_W-1:0] drop_top(input logic [C_W-1:0] v);
    return (v == TOP) ? '0 : v;
  endfunction

  function automatic logic [C_W-1:0] mod_p(input logic [ADDR_W-1:0] a);
    logic [PAD_W-1:0] p;
    logic [C_W-1:0]   acc;
    p   = PAD_W'(a);
    acc = '0;
    for (int i = 0; i < NCH; i++) acc = eac_add(acc, p[i*C_W +: C_W]);
    return drop_top(acc);
  endfunction

  logic [C_W-1:0]    stride_mod;
  logic [ADDR_W-1:0] look_addr;
  logic [C_W-1:0]    look_idx;
  logic              hit_now;
  logic [LINES-1:0]  line_vld;
  logic [ADDR_W-1:0] line_tag [LINES];

  assign idx_out   = mod_p(req_addr);
  assign tag_out   = req_addr;
  assign look_addr = req_sel_seq ? seq_addr  : req_addr;
  assign look_idx  = req_sel_seq ? seq_index : idx_out;
  assign hit_now   = line_vld[look_idx] && (line_tag[look_idx] == look_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_addr   <= '0;
      seq_index  <= '0;
      stride_mod <= '0;
    end else if (seq_load) begin
      seq_addr   <= seq_base;
      seq_index  <= mod_p(seq_base);
      stride_mod <= mod_p(seq_stride);
    end else if (seq_step) begin
      seq_addr   <= seq_addr + stride_q;
      seq_index  <= drop_top(eac_add(seq_index, stride_mod));
    end
  end

  logic [ADDR_W-1:0] stride_q;
  always_ff @(posedge clk) begin
    if (!rst_n)        stride_q <= '0;
    else if (seq_load) stride_q <= seq_stride;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_vld  <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_index <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit   <= hit_now;
        rsp_index <= look_idx;
        if (!hit_now) line_vld[look_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid && !hit_now) line_tag[look_idx] <= look_addr;
  end
endmodule

// File: rtl/mersenne_line_mapper_chk.sv
module mersenne_line_mapper_chk #(
  parameter int ADDR_W = 16,
  parameter int C_W    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_sel_seq,
  input logic [ADDR_W-1:0] req_addr,
  input logic [C_W-1:0]    idx_out,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [C_W-1:0]    rsp_index,
  input logic              seq_load,
  input logic              seq_step,
  input logic [ADDR_W-1:0] seq_base,
  input logic [ADDR_W-1:0] seq_stride,
  input logic [ADDR_W-1:0] seq_addr,
  input logic [C_W-1:0]    seq_index
);
  localparam logic [ADDR_W-1:0] P_A = ADDR_W'((1 << C_W) - 1);
  localparam logic [C_W-1:0]    TOP = '1;

  logic [ADDR_W-1:0] stride_c;
  logic              wrapped;
  logic [ADDR_W:0]   step_sum;
  assign step_sum = {1'b0, seq_addr} + {1'b0, stride_c};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stride_c <= '0;
      wrapped  <= 1'b0;
    end else if (seq_load) begin
      stride_c <= seq_stride;
      wrapped  <= 1'b0;
    end else if (seq_step && step_sum[ADDR_W]) begin
      wrapped  <= 1'b1;
    end
  end

  a_r1_index_mod: assert property (@(posedge clk) disable iff (!rst_n)
    idx_out == C_W'(req_addr % P_A));

  a_r2_no_top_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_index != TOP);

  a_r2_no_top_seq: assert property (@(posedge clk) disable iff (!rst_n)
    seq_index != TOP);

  a_r5_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r5_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r5_rsp_index: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_sel_seq) |=> rsp_index == C_W'($past(req_addr) % P_A));

  a_r6_repeat_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_sel_seq && $past(req_valid) && !$past(req_sel_seq)
     && req_addr == $past(req_addr)) |=> rsp_hit);

  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    seq_load |=> seq_addr == $past(seq_base));

  a_r8_seq_mod: assert property (@(posedge clk) disable iff (!rst_n)
    !wrapped |-> seq_index == C_W'(seq_addr % P_A));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_load && !seq_step) |=> ($stable(seq_addr) && $stable(seq_index)));
endmodule

bind mersenne_line_mapper mersenne_line_mapper_chk #(.ADDR_W(ADDR_W), .C_W(C_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel_seq(req_sel_seq),
  .req_addr(req_addr), .idx_out(idx_out), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_index(rsp_index), .seq_load(seq_load), .seq_step(seq_step),
  .seq_base(seq_base), .seq_stride(seq_stride), .seq_addr(seq_addr),
  .seq_index(seq_index)
);

// File: tb/tb_mersenne_line_mapper.sv
module tb_mersenne_line_mapper;
  localparam int AW = 16;
  localparam int CW = 5;
  localparam int P  = 31;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          req_valid = 0, req_sel_seq = 0, seq_load = 0, seq_step = 0;
  logic [AW-1:0] req_addr = '0, seq_base = '0, seq_stride = '0;
  logic [CW-1:0] idx_out, rsp_index, seq_index;
  logic [AW-1:0] tag_out, seq_addr;
  logic          rsp_valid, rsp_hit;

  mersenne_line_mapper #(.ADDR_W(AW), .C_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel_seq(req_sel_seq),
    .req_addr(req_addr), .idx_out(idx_out), .tag_out(tag_out),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_index(rsp_index),
    .seq_load(seq_load), .seq_step(seq_step), .seq_base(seq_base),
    .seq_stride(seq_stride), .seq_addr(seq_addr), .seq_index(seq_index));

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 0;
  bit          mdl_vld [P];
  logic [AW-1:0] mdl_tag [P];

  localparam logic [20:0] VEC [12] = '{
    {16'd0,     5'd0},  {16'd31,    5'd0},  {16'd30,    5'd30},
    {16'd32,    5'd1},  {16'd65535, 5'd1},  {16'd1000,  5'd8},
    {16'd4096,  5'd4},  {16'h7C00,  5'd0},  {16'd12345, 5'd7},
    {16'd961,   5'd0},  {16'd993,   5'd1},  {16'd65534, 5'd0}};

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic lookup(input logic [AW-1:0] a, input bit sel, input int eidx, input string r);
    bit ehit;
    ehit = mdl_vld[eidx] && (mdl_tag[eidx] == a);
    @(negedge clk);
    req_valid = 1; req_sel_seq = sel;
    if (!sel) req_addr = a;
    @(negedge clk);
    req_valid = 0; req_sel_seq = 0;
    check({r, " R5 rsp_valid"}, rsp_valid, 1);
    check({r, " R5 rsp_index"}, rsp_index, eidx);
    check({r, " R6 rsp_hit"}, rsp_hit, ehit);
    if (!ehit) begin mdl_vld[eidx] = 1; mdl_tag[eidx] = a; end
  endtask

  task automatic seq_pulse(input bit ld, input bit st, input logic [AW-1:0] b, input logic [AW-1:0] s);
    @(negedge clk);
    seq_load = ld; seq_step = st; seq_base = b; seq_stride = s;
    @(negedge clk);
    seq_load = 0; seq_step = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a;
    int base;
    for (int i = 0; i < P; i++) mdl_vld[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check("R11 rsp_valid", rsp_valid, 0);
    check("R11 seq_addr", seq_addr, 0);
    check("R11 seq_index", seq_index, 0);
    check("R5 idle rsp_valid", rsp_valid, 0);
    lookup(16'd0, 0, 0, "R11 cold miss");

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      req_addr = VEC[i][20:5];
      #1;
      check("R1 idx_out", idx_out, VEC[i][4:0]);
      check("R3 tag_out", tag_out, VEC[i][20:5]);
      lookup(VEC[i][20:5], 0, int'(VEC[i][4:0]), "R6 table");
    end

    lookup(16'd65534, 0, 0, "R6 repeat");
    lookup(16'd5, 0, 5, "R6 fill");
    lookup(16'd36, 0, 5, "R6 conflict");
    lookup(16'd5, 0, 5, "R6 evicted");

    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      req_addr = AW'(k * 32);
      #1;
      check("R4 pow2 stride", idx_out, k);
    end
    @(negedge clk); req_addr = 16'd62; #1;
    check("R2 multiple of P", idx_out, 0);

    seq_pulse(1, 0, 16'd100, 16'd64);
    check("R7 seq_addr", seq_addr, 100);
    check("R7 seq_index", seq_index, 100 % P);
    for (int k = 1; k <= 6; k++) begin
      seq_pulse(0, 1, 16'd0, 16'd0);
      check("R8 seq_addr", seq_addr, 100 + 64 * k);
      check("R8 seq_index", seq_index, (100 + 64 * k) % P);
    end
    @(negedge clk); @(negedge clk);
    check("R9 hold addr", seq_addr, 100 + 64 * 6);
    check("R9 hold index", seq_index, (100 + 64 * 6) % P);

    seq_pulse(1, 1, 16'd5, 16'd3);
    check("R9 load wins addr", seq_addr, 5);
    check("R9 load wins index", seq_index, 5);

    @(negedge clk); req_addr = 16'd999;
    lookup(16'd5, 1, 5, "R10 seq source");

    base = 40;
    seq_pulse(1, 0, AW'(base), 16'd31);
    for (int k = 1; k <= 3; k++) begin
      seq_pulse(0, 1, 16'd0, 16'd0);
      check("R8 stride P addr", seq_addr, base + 31 * k);
      check("R8 stride P index", seq_index, base % P);
    end
    a = seq_addr;
    lookup(a, 1, base % P, "R10 seq lookup");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule